// File: doc/BRIEF.md
# Retired Front-End Miss Counter

This block counts front-end miss events and charges each one to an instruction that actually retires. Each cycle the retirement stage presents one slot record. The record carries a valid bit, a retired-or-squashed bit, a miss flag, a multi-uop bubble flag and a macro-fusion flag. It also carries an end-of-instruction marker and the cache-line tags of the instruction's first and last bytes. A separate strobe reports a miss that occurred between instruction boundaries.

The records that make up one instruction are merged into a single event. An instruction can span several records in two ways: the uops of a multi-uop instruction, and the two halves of a fused pair. A line filter then suppresses events that fall in the line counted last. The surviving events step a counter of programmable width. Software can load this counter, and the counter raises a one-cycle overflow pulse when it wraps to zero. Fetch, decode and the cache hierarchy are not part of the block. The miss and bubble indications arrive as tagged inputs.

Top module: `fe_miss_ctr`

## Requirements
- R1: A record with valid=1 and retired=0 (squashed) never changes the count, and it discards any partially merged instruction that precedes it.
- R2: An instruction event is suppressed when its first-byte line tag equals the stored tag of the last line that produced an event. After every instruction that has an event, the stored tag becomes that instruction's last-byte line tag.
- R3: An instruction whose first and last byte tags differ is counted at most once. A following instruction that starts in its second line is suppressed.
- R4: Retiring records with eoi=0 are the leading uops of one instruction. Their miss and bubble flags merge into a single event, evaluated when the record with eoi=1 retires.
- R5: A retiring record with fused=1 is the first half of a fused pair and merges with the next retiring record. Either half missing, or both, gives one event.
- R6: An out-of-boundary strobe sets a pending miss, which is charged to the next retiring record. A strobe in the same cycle as a retiring record is charged to the record after that one.
- R7: A pending miss and the charged instruction's own miss produce one increment, not two.
- R8: While enable_i=0, events do not change the count. In that state the stored line tag, the pending miss and any partial instruction are cleared.
- R9: load_i=1 writes load_val_i into the counter on the next edge, taking priority over an increment in that cycle.
- R10: An increment from the all-ones value gives zero, and ovf_o is 1 for exactly that cycle.
- R11: After reset the count and ovf_o are zero and no miss is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Counting enable |
| slot_valid_i | input | 1 | Slot record present |
| slot_retired_i | input | 1 | 1 = retired, 0 = squashed |
| slot_miss_i | input | 1 | Front-end miss flag |
| slot_bubble_i | input | 1 | Multi-uop allocation bubble flag |
| slot_fused_i | input | 1 | First half of a macro-fused pair |
| slot_eoi_i | input | 1 | Last uop of the instruction |
| slot_tag_first_i | input | TAG_W | Line tag of the first instruction byte |
| slot_tag_last_i | input | TAG_W | Line tag of the last instruction byte |
| oob_miss_i | input | 1 | Miss outside an instruction boundary |
| load_i | input | 1 | Counter load strobe |
| load_val_i | input | CNT_W | Counter load value |
| count_o | output | CNT_W | Event count |
| ovf_o | output | 1 | Wrap-to-zero pulse |

## Verification
The bench builds the block with CNT_W=12 and TAG_W=4. The narrow tag means random instruction streams hit the same line often, so duplicate suppression and the handover of the spanning line occur constantly rather than rarely. The 12-bit counter lets a directed load of the all-ones value reach the wrap and overflow pulse in a single cycle. The random loads land anywhere in the counter's range.

// File: rtl/fe_miss_pkg.sv
package fe_miss_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE,
    SLOT_SQUASH,
    SLOT_RETIRE
  } slot_kind_e;

  function automatic slot_kind_e slot_kind(input logic en, input logic vld, input logic ret);
    if (!en || !vld) return SLOT_IDLE;
    return ret ? SLOT_RETIRE : SLOT_SQUASH;
  endfunction
endpackage

// File: rtl/fe_attrib_tracker.sv
module fe_attrib_tracker
  import fe_miss_pkg::*;
#(
  parameter int unsigned TAG_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             valid_i,
  input  logic             retired_i,
  input  logic             miss_i,
  input  logic             bubble_i,
  input  logic             fused_i,
  input  logic             eoi_i,
  input  logic [TAG_W-1:0] tag_first_i,
  input  logic             oob_i,
  output logic             commit_o,
  output logic             hit_o,
  output logic [TAG_W-1:0] tag_first_o
);
  slot_kind_e kind;
  logic grp_act_q, grp_hit_q, pend_q;
  logic [TAG_W-1:0] grp_tag_q;
  logic closing;

  assign kind        = slot_kind(enable_i, valid_i, retired_i);
  assign hit_o       = grp_hit_q | miss_i | bubble_i | pend_q;
  assign tag_first_o = grp_act_q ? grp_tag_q : tag_first_i;
  assign closing     = (kind == SLOT_RETIRE) && eoi_i && !fused_i;
  assign commit_o    = closing;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_act_q <= 1'b0;
      grp_hit_q <= 1'b0;
      grp_tag_q <= '0;
      pend_q    <= 1'b0;
    end else if (!enable_i) begin
      grp_act_q <= 1'b0;
      grp_hit_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      // strobe in a retiring cycle is deferred to the following record
      pend_q <= (pend_q && kind != SLOT_RETIRE) || oob_i;
      unique case (kind)
        SLOT_SQUASH: begin
          grp_act_q <= 1'b0;
          grp_hit_q <= 1'b0;
        end
        SLOT_RETIRE: begin
          if (closing) begin
            grp_act_q <= 1'b0;
            grp_hit_q <= 1'b0;
          end else begin
            grp_act_q <= 1'b1;
            grp_hit_q <= hit_o;
            grp_tag_q <= tag_first_o;
          end
        end
        default: ;
      endcase
    end
  end

  AST_PEND_CLEARED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !pend_q); // R8
  AST_PEND_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == SLOT_RETIRE && !oob_i) |=> !pend_q); // R6
  AST_SQUASH_DROPS_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == SLOT_SQUASH) |=> !grp_act_q && !grp_hit_q); // R1
endmodule

// File: rtl/fe_line_filter.sv
module fe_line_filter #(
  parameter int unsigned TAG_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             commit_i,
  input  logic             hit_i,
  input  logic [TAG_W-1:0] tag_first_i,
  input  logic [TAG_W-1:0] tag_last_i,
  output logic             inc_o
);
  logic             tag_v_q;
  logic [TAG_W-1:0] tag_q;
  logic             same_line;

  assign same_line = tag_v_q && (tag_first_i == tag_q);
  assign inc_o     = commit_i && hit_i && !same_line;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_v_q <= 1'b0;
      tag_q   <= '0;
    end else if (!enable_i) begin
      tag_v_q <= 1'b0;
    end else if (commit_i && hit_i) begin
      tag_v_q <= 1'b1;
      tag_q   <= tag_last_i;
    end
  end

  AST_TAG_CLEARED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !tag_v_q); // R8
  AST_LAST_LINE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && commit_i && hit_i) |=> tag_v_q && tag_q == $past(tag_last_i)); // R3
endmodule

// File: rtl/fe_event_counter.sv
module fe_event_counter #(
  parameter int unsigned CNT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= inc_i && !load_i && (cnt_q == CNT_MAX);
      if (load_i)     cnt_q <= load_val_i;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;

  AST_OVF_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> count_o == '0); // R10
  AST_OVF_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o); // R10
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(load_val_i)); // R9
endmodule

// File: rtl/fe_miss_ctr.sv
module fe_miss_ctr #(
  parameter int unsigned CNT_W = 48,
  parameter int unsigned TAG_W = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             slot_valid_i,
  input  logic             slot_retired_i,
  input  logic             slot_miss_i,
  input  logic             slot_bubble_i,
  input  logic             slot_fused_i,
  input  logic             slot_eoi_i,
  input  logic [TAG_W-1:0] slot_tag_first_i,
  input  logic [TAG_W-1:0] slot_tag_last_i,
  input  logic             oob_miss_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic             commit, hit, inc;
  logic [TAG_W-1:0] grp_tag_first;

  fe_attrib_tracker #(.TAG_W(TAG_W)) i_tracker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .valid_i     (slot_valid_i),
    .retired_i   (slot_retired_i),
    .miss_i      (slot_miss_i),
    .bubble_i    (slot_bubble_i),
    .fused_i     (slot_fused_i),
    .eoi_i       (slot_eoi_i),
    .tag_first_i (slot_tag_first_i),
    .oob_i       (oob_miss_i),
    .commit_o    (commit),
    .hit_o       (hit),
    .tag_first_o (grp_tag_first)
  );

  fe_line_filter #(.TAG_W(TAG_W)) i_filter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .commit_i    (commit),
    .hit_i       (hit),
    .tag_first_i (grp_tag_first),
    .tag_last_i  (slot_tag_last_i),
    .inc_o       (inc)
  );

  fe_event_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (inc),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .count_o    (count_o),
    .ovf_o      (ovf_o)
  );

  AST_SQUASH_NO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_valid_i && !slot_retired_i && !load_i) |=> $stable(count_o)); // R1
  AST_DISABLED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !load_i) |=> $stable(count_o)); // R8
  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1)); // R7
endmodule

// File: tb/test_fe_miss_ctr.sv
module test_fe_miss_ctr;
  localparam int unsigned CNT_W = 12;
  localparam int unsigned TAG_W = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic en, vld, ret, miss, bub, fus, eoi, oob, load;
  logic [TAG_W-1:0] tf, tl;
  logic [CNT_W-1:0] lval, count;
  logic ovf;
  int n_chk = 0, n_err = 0;

  // reference state
  logic [CNT_W-1:0] m_cnt = '0;
  logic m_ovf = 1'b0, m_pend = 1'b0, m_tv = 1'b0, m_ga = 1'b0, m_gh = 1'b0;
  logic [TAG_W-1:0] m_tag = '0, m_gt = '0;

  always #2 clk = ~clk;

  fe_miss_ctr #(.CNT_W(CNT_W), .TAG_W(TAG_W)) i_fe_miss_ctr (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(en),
    .slot_valid_i(vld), .slot_retired_i(ret), .slot_miss_i(miss),
    .slot_bubble_i(bub), .slot_fused_i(fus), .slot_eoi_i(eoi),
    .slot_tag_first_i(tf), .slot_tag_last_i(tl), .oob_miss_i(oob),
    .load_i(load), .load_val_i(lval), .count_o(count), .ovf_o(ovf));

  task automatic check(string req, logic [CNT_W-1:0] got, logic [CNT_W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // reference model, evaluated with the inputs present at the edge
  task automatic model();
    logic rtr, hit, close, inc;
    logic [TAG_W-1:0] t0;
    rtr = en && vld && ret;
    hit = m_gh || miss || bub || m_pend;
    t0  = m_ga ? m_gt : tf;
    close = rtr && eoi && !fus;
    inc = close && hit && !(m_tv && t0 == m_tag);
    m_ovf = inc && !load && (m_cnt == '1);
    if (load) m_cnt = lval; else if (inc) m_cnt = m_cnt + 1'b1;
    if (!en) begin
      m_tv = 0; m_pend = 0; m_ga = 0; m_gh = 0;
    end else begin
      if (close && hit) begin m_tv = 1; m_tag = tl; end
      m_pend = (m_pend && !rtr) || oob;
      if (vld && !ret) begin m_ga = 0; m_gh = 0; end
      else if (close) begin m_ga = 0; m_gh = 0; end
      else if (rtr) begin m_ga = 1; m_gh = hit; m_gt = t0; end
    end
  endtask

  task automatic idle();
    vld = 0; ret = 0; miss = 0; bub = 0; fus = 0; eoi = 0; oob = 0; load = 0;
  endtask

  task automatic cyc(string req);
    @(posedge clk);
    model();
    #1;
    check(req, count, m_cnt);
    check(req, {{(CNT_W-1){1'b0}}, ovf}, {{(CNT_W-1){1'b0}}, m_ovf});
    @(negedge clk);
    idle();
  endtask

  task automatic rec(logic r, logic m, logic b, logic f, logic e,
                     logic [TAG_W-1:0] a, logic [TAG_W-1:0] z, string req);
    vld = 1; ret = r; miss = m; bub = b; fus = f; eoi = e; tf = a; tl = z;
    cyc(req);
  endtask

  task automatic expect_cnt(string req, logic [CNT_W-1:0] e);
    check(req, count, e);
  endtask

  initial begin
    #200000;
    n_err++;
    $display("FAIL watchdog: got hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] base;
    void'($urandom(32'd1234));
    en = 1; tf = 0; tl = 0; lval = 0; idle();
    #9 rst_ni = 1;
    @(negedge clk);
    expect_cnt("R11", '0);
    cyc("R11");
    // R1 squashed miss adds nothing
    rec(0, 1, 0, 0, 1, 4'd1, 4'd1, "R1");
    expect_cnt("R1", '0);
    // R2 first miss counts, same line suppressed
    rec(1, 1, 0, 0, 1, 4'd2, 4'd2, "R2");
    expect_cnt("R2", 12'd1);
    rec(1, 1, 0, 0, 1, 4'd2, 4'd2, "R2");
    expect_cnt("R2", 12'd1);
    // R3 spanning line 5->6, next in line 6 suppressed
    rec(1, 1, 0, 0, 1, 4'd5, 4'd6, "R3");
    rec(1, 1, 0, 0, 1, 4'd6, 4'd6, "R3");
    expect_cnt("R3", 12'd2);
    // R4 three-uop instruction with bubbles: one count
    rec(1, 0, 1, 0, 0, 4'd8, 4'd8, "R4");
    rec(1, 0, 1, 0, 0, 4'd8, 4'd8, "R4");
    expect_cnt("R4", 12'd2);
    rec(1, 0, 1, 0, 1, 4'd8, 4'd8, "R4");
    expect_cnt("R4", 12'd3);
    // R5 fused pair, both miss: one count
    rec(1, 1, 0, 1, 1, 4'd10, 4'd10, "R5");
    rec(1, 1, 0, 0, 1, 4'd11, 4'd11, "R5");
    expect_cnt("R5", 12'd4);
    // R6 strobe deferred past the retiring record in its cycle
    oob = 1; rec(1, 0, 0, 0, 1, 4'd12, 4'd12, "R6");
    expect_cnt("R6", 12'd4);
    rec(1, 0, 0, 0, 1, 4'd13, 4'd13, "R6");
    expect_cnt("R6", 12'd5);
    // R7 pending plus own miss in one line: one increment
    oob = 1; cyc("R7");
    rec(1, 1, 0, 0, 1, 4'd0, 4'd0, "R7");
    expect_cnt("R7", 12'd6);
    // R8 disable: no count, tag and pending cleared
    en = 0; oob = 1; rec(1, 1, 0, 0, 1, 4'd3, 4'd3, "R8");
    expect_cnt("R8", 12'd6);
    en = 1;
    rec(1, 1, 0, 0, 1, 4'd0, 4'd0, "R8");
    expect_cnt("R8", 12'd7);
    rec(1, 0, 0, 0, 1, 4'd9, 4'd9, "R8");
    expect_cnt("R8", 12'd7);
    // R9 load beats increment
    load = 1; lval = 12'hFFF; rec(1, 1, 0, 0, 1, 4'd14, 4'd14, "R9");
    expect_cnt("R9", 12'hFFF);
    // R10 wrap and single-cycle pulse
    rec(1, 1, 0, 0, 1, 4'd15, 4'd15, "R10");
    check("R10", {11'd0, ovf}, 12'd1);
    cyc("R10");
    check("R10", {11'd0, ovf}, 12'd0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      en = ($urandom % 50) != 0;
      vld = ($urandom % 4) != 0;
      ret = ($urandom % 6) != 0;
      miss = ($urandom % 3) == 0;
      bub = ($urandom % 8) == 0;
      fus = ($urandom % 6) == 0;
      eoi = ($urandom % 4) != 0;
      oob = ($urandom % 10) == 0;
      tf = 4'($urandom % 5);
      tl = ($urandom % 4 == 0) ? tf + 1'b1 : tf;
      load = ($urandom % 200) == 0;
      base = 12'($urandom);
      lval = ($urandom % 2 == 0) ? 12'hFFE : base;
      cyc("R2");
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule